// File: doc/BRIEF.md
# Display Bridge PLL Setting Calculator

This block turns two numbers into the clock settings of a parallel-to-serial display bridge. The numbers are the frequency of the reference clock in kHz and the wanted serial bit rate of one lane in kbps. It returns a 16-bit PLL configuration word and a 6-bit code that sets the low-power clock divider. A start pulse captures both operands. A small sequencer then works through the result in steps. It uses one shift-and-add multiplier and one restoring shift-and-subtract divider, so no combinational divider is needed.

The work runs in a fixed order. First a loop picks the pre-divider, which keeps the divided reference at or above a minimum intermediate frequency. Next comes the multiplier, rounded up. The resulting PLL rate selects one of four frequency range codes. Last, the PLL rate is computed again from the packed fields, and the low-power divider count is derived from it. The results stay on the outputs until the next start, and `done` marks them as valid.

Top module: `dsi_pll_calc`

## Requirements
- R1: While reset is asserted, and after it until the first run completes, `busy`, `done`, `pll_word` and `lp_code` are all zero.
- R2: The pre-divider D sits in `pll_word[12:8]`. It equals floor(ref/5000), with values under 1 raised to 1 and values over 31 capped at 31. This is the largest value in 1..31 that keeps ref/D at or above 5000 kHz.
- R3: The multiplier M is ceiling(rate × D / ref). `pll_word[7:0]` carries the low 8 bits of M.
- R4: `pll_word[15:14]` holds the range code. It is computed from P = floor(ref × M / D), using the full M: 3 when P ≥ 501000, 2 when P ≥ 251000, 1 when P ≥ 126000, and 0 otherwise.
- R5: `pll_word[13]` is always 0.
- R6: Let M8 be `pll_word[7:0]`, replaced by 1 when it is zero. Then Q = floor(ref × M8 / D) and N = ceiling(Q / 80000). `lp_code` is (N − 1) modulo 64.
- R7: The operands are captured at the start pulse. Input changes during a run, and start pulses during a run, do not change that run's results. When no run is in progress, the outputs hold their values until the next accepted start.
- R8: `busy` goes high one clock after a start that is accepted while idle. `done` is never high while `busy` is high. `done` rises in the same clock that `busy` falls, and it stays high until the next accepted start.
- R9: A run finishes within a bounded number of cycles set only by the parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted only while idle |
| ref_khz | input | FREQ_W | Reference clock frequency in kHz |
| lane_kbps | input | FREQ_W | Target bit rate per lane in kbps |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | Results valid |
| pll_word | output | 16 | Packed range code, pre-divider and multiplier |
| lp_code | output | 6 | Low-power clock divider field |

## Verification
A faulty pre-divider search shows up directly in the divider field once the run ends. It also spreads into the multiplier, the range code and the low-power code, because each later stage divides by that divider. A wrong step in the multiplier or the divider sequence produces a wrong field no more than a few hundred cycles after the start. The reference vectors are chosen so that the PLL rate falls exactly on each range threshold and just below it, where an off-by-one in the rounding changes the code. A sequencer that stalls is caught by the latency bound, and a sequencer that overwrites held results is caught by the output-stability check.

// File: rtl/dsi_pll_pkg.sv
package dsi_pll_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_SRCH,
      ST_M1,
      ST_D1,
      ST_M2,
      ST_D2,
      ST_M3,
      ST_D3,
      ST_D4
   } calc_st_e;

   localparam longint unsigned BAND3_KBPS = 64'd501000;
   localparam longint unsigned BAND2_KBPS = 64'd251000;
   localparam longint unsigned BAND1_KBPS = 64'd126000;

   function automatic logic [1:0] band_of(input longint unsigned pll_kbps);
      if (pll_kbps >= BAND3_KBPS)      return 2'd3;
      else if (pll_kbps >= BAND2_KBPS) return 2'd2;
      else if (pll_kbps >= BAND1_KBPS) return 2'd1;
      else                             return 2'd0;
   endfunction

endpackage

// File: rtl/dsi_pll_seq_mul.sv
module dsi_pll_seq_mul #(
   parameter int W = 56
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] prod,
   output logic         fin
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  mc_q;
   logic [W-1:0]  mp_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prod  <= '0;
         mc_q  <= '0;
         mp_q  <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            prod  <= '0;
            mc_q  <= a;
            mp_q  <= b;
            cnt_q <= '0;
            run_q <= 1'b1;
         end else if (run_q) begin
            if (mp_q[0]) prod <= prod + mc_q;
            mc_q  <= mc_q << 1;
            mp_q  <= mp_q >> 1;
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == CW'(W - 1)) begin
               run_q <= 1'b0;
               fin   <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dsi_pll_seq_div.sv
module dsi_pll_seq_div #(
   parameter int W = 56
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic [W-1:0] quo,
   output logic         fin
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  rem_q;
   logic [CW-1:0] cnt_q;
   logic          run_q;
   logic [W:0]    shifted;
   logic [W:0]    diff;
   logic          fits;

   always_comb begin
      shifted = {rem_q, quo[W-1]};
      diff    = shifted - {1'b0, den};
      fits    = shifted >= {1'b0, den};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo   <= '0;
         rem_q <= '0;
         cnt_q <= '0;
         run_q <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            quo   <= num;
            rem_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= fits ? diff[W-1:0] : shifted[W-1:0];
            quo   <= {quo[W-2:0], fits};
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == CW'(W - 1)) begin
               run_q <= 1'b0;
               fin   <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/dsi_pll_calc.sv
module dsi_pll_calc
   import dsi_pll_pkg::*;
#(
   parameter int FREQ_W       = 24,
   parameter int IF_MIN_KHZ   = 5000,
   parameter int PREDIV_MAX   = 31,
   parameter int LP_CLK_KHZ   = 10000,
   parameter int LP_BYTE_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] ref_khz,
   input  logic [FREQ_W-1:0] lane_kbps,
   output logic              busy,
   output logic              done,
   output logic [15:0]       pll_word,
   output logic [5:0]        lp_code
);
   localparam int PW        = 2 * FREQ_W + 8;
   localparam int DW        = 5;
   localparam int MW        = 8;
   localparam int LW        = 6;
   localparam int LP_STEP   = LP_CLK_KHZ * LP_BYTE_BITS;
   localparam int LAT_LIMIT = PREDIV_MAX + 8 + 7 * (PW + 3);

   if (PREDIV_MAX < 1 || PREDIV_MAX > 31) begin : g_bad_prediv
      $error("PREDIV_MAX must fit the 5-bit divider field");
   end
   if (PW > 64) begin : g_bad_width
      $error("FREQ_W too large for the 64-bit band compare");
   end
   if (FREQ_W < 18) begin : g_bad_freq
      $error("FREQ_W too small for the band thresholds");
   end

   calc_st_e          st_q;
   logic              kick_q;
   logic [FREQ_W-1:0] ref_q;
   logic [FREQ_W-1:0] tgt_q;
   logic [DW-1:0]     pdiv_q;
   logic [PW-1:0]     thr_q;
   logic [PW-1:0]     mfull_q;
   logic [1:0]        band_q;

   logic [PW-1:0] ref_x;
   logic [PW-1:0] tgt_x;
   logic [PW-1:0] pdiv_x;
   logic [PW-1:0] mfix;
   logic [PW-1:0] mul_a;
   logic [PW-1:0] mul_b;
   logic [PW-1:0] mul_p;
   logic          mul_go;
   logic          mul_fin;
   logic [PW-1:0] div_n;
   logic [PW-1:0] div_d;
   logic [PW-1:0] div_q;
   logic          div_go;
   logic          div_fin;

   assign ref_x  = PW'(ref_q);
   assign tgt_x  = PW'(tgt_q);
   assign pdiv_x = PW'(pdiv_q);
   assign mfix   = (mfull_q[MW-1:0] == '0) ? PW'(1) : PW'(mfull_q[MW-1:0]);
   assign busy   = (st_q != ST_IDLE);

   always_comb begin
      mul_a  = (st_q == ST_M1) ? tgt_x : ref_x;
      case (st_q)
         ST_M1:   mul_b = pdiv_x;
         ST_M2:   mul_b = mfull_q;
         default: mul_b = mfix;
      endcase
      mul_go = kick_q && (st_q == ST_M1 || st_q == ST_M2 || st_q == ST_M3);

      case (st_q)
         ST_D1: begin
            div_n = mul_p + ref_x - PW'(1);
            div_d = ref_x;
         end
         ST_D4: begin
            div_n = div_q + PW'(LP_STEP - 1);
            div_d = PW'(LP_STEP);
         end
         default: begin
            div_n = mul_p;
            div_d = pdiv_x;
         end
      endcase
      div_go = kick_q && (st_q == ST_D1 || st_q == ST_D2 ||
                          st_q == ST_D3 || st_q == ST_D4);
   end

   dsi_pll_seq_mul #(.W(PW)) mul_i (
      .clk(clk), .rst_n(rst_n), .go(mul_go),
      .a(mul_a), .b(mul_b), .prod(mul_p), .fin(mul_fin)
   );

   dsi_pll_seq_div #(.W(PW)) div_i (
      .clk(clk), .rst_n(rst_n), .go(div_go),
      .num(div_n), .den(div_d), .quo(div_q), .fin(div_fin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         kick_q   <= 1'b0;
         ref_q    <= '0;
         tgt_q    <= '0;
         pdiv_q   <= '0;
         thr_q    <= '0;
         mfull_q  <= '0;
         band_q   <= '0;
         done     <= 1'b0;
         pll_word <= '0;
         lp_code  <= '0;
      end else begin
         kick_q <= 1'b0;
         case (st_q)
            ST_IDLE: if (start) begin
               ref_q  <= ref_khz;
               tgt_q  <= lane_kbps;
               pdiv_q <= DW'(1);
               thr_q  <= PW'(2 * IF_MIN_KHZ);
               done   <= 1'b0;
               st_q   <= ST_SRCH;
            end
            ST_SRCH: begin
               if (pdiv_q < DW'(PREDIV_MAX) && ref_x >= thr_q) begin
                  pdiv_q <= pdiv_q + DW'(1);
                  thr_q  <= thr_q + PW'(IF_MIN_KHZ);
               end else begin
                  st_q   <= ST_M1;
                  kick_q <= 1'b1;
               end
            end
            ST_M1: if (mul_fin) begin
               st_q   <= ST_D1;
               kick_q <= 1'b1;
            end
            ST_D1: if (div_fin) begin
               mfull_q <= div_q;
               st_q    <= ST_M2;
               kick_q  <= 1'b1;
            end
            ST_M2: if (mul_fin) begin
               st_q   <= ST_D2;
               kick_q <= 1'b1;
            end
            ST_D2: if (div_fin) begin
               band_q <= band_of(64'(div_q));
               st_q   <= ST_M3;
               kick_q <= 1'b1;
            end
            ST_M3: if (mul_fin) begin
               st_q   <= ST_D3;
               kick_q <= 1'b1;
            end
            ST_D3: if (div_fin) begin
               st_q   <= ST_D4;
               kick_q <= 1'b1;
            end
            ST_D4: if (div_fin) begin
               lp_code  <= LW'(div_q - PW'(1));
               pll_word <= {band_q, 1'b0, pdiv_q, mfull_q[MW-1:0]};
               done     <= 1'b1;
               st_q     <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dsi_pll_calc_chk.sv
module dsi_pll_calc_chk #(
   parameter int LAT_LIMIT = 500
) (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic        done,
   input logic [15:0] pll_word,
   input logic [5:0]  lp_code
);
   localparam int CW = $clog2(LAT_LIMIT + 2) + 1;

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          run_cnt <= '0;
      else if (!busy)                      run_cnt <= '0;
      else if (run_cnt != {CW{1'b1}})      run_cnt <= run_cnt + CW'(1);
   end

   // R8
   busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R8
   done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));

   // R8
   done_with_busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(busy));

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(pll_word) && $stable(lp_code)));

   // R5
   reserved_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pll_word[13] == 1'b0);

   // R2
   prediv_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pll_word[12:8] != 5'd0));

   // R9
   latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_cnt <= CW'(LAT_LIMIT));
endmodule

bind dsi_pll_calc dsi_pll_calc_chk #(.LAT_LIMIT(LAT_LIMIT)) chk_i (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .pll_word(pll_word), .lp_code(lp_code)
);

// File: tb/dsi_pll_calc_tb_top.sv
module dsi_pll_calc_tb_top;
   localparam int FW = 24;
   localparam int NV = 14;

   // each entry: {reference kHz, lane kbps}
   localparam logic [47:0] VEC [NV] = '{
      {24'd27000,  24'd500000},
      {24'd1000,   24'd501000},
      {24'd1000,   24'd500000},
      {24'd1000,   24'd251000},
      {24'd1000,   24'd250000},
      {24'd1000,   24'd126000},
      {24'd1000,   24'd125000},
      {24'd9999,   24'd300000},
      {24'd10000,  24'd300000},
      {24'd155000, 24'd1000000},
      {24'd200000, 24'd1000000},
      {24'd12000,  24'd2000000},
      {24'd20000,  24'd0},
      {24'd24000,  24'd480000}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [FW-1:0] ref_khz = '0;
   logic [FW-1:0] lane_kbps = '0;
   logic          busy;
   logic          done;
   logic [15:0]   pll_word;
   logic [5:0]    lp_code;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;

   dsi_pll_calc #(.FREQ_W(FW)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .ref_khz(ref_khz),
      .lane_kbps(lane_kbps), .busy(busy), .done(done),
      .pll_word(pll_word), .lp_code(lp_code)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model(input longint r, input longint t,
                        output logic [15:0] w, output logic [5:0] lp);
      longint d, m, p, m8, q, n;
      logic [1:0] band;
      d = r / 5000;
      if (d < 1) d = 1;
      if (d > 31) d = 31;
      m = (t * d + r - 1) / r;
      p = r * m / d;
      if (p >= 501000)      band = 2'd3;
      else if (p >= 251000) band = 2'd2;
      else if (p >= 126000) band = 2'd1;
      else                  band = 2'd0;
      m8 = m % 256;
      w = {band, 1'b0, 5'(d), 8'(m8)};
      if (m8 == 0) m8 = 1;
      q = r * m8 / d;
      n = (q + 79999) / 80000;
      lp = 6'(n - 1);
   endtask

   task automatic kick(input logic [FW-1:0] r, input logic [FW-1:0] t);
      @(negedge clk);
      ref_khz = r;
      lane_kbps = t;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done) begin
         @(negedge clk);
         n++;
         if (n > 5000) begin
            check("R9 watchdog", 0, 1);
            break;
         end
      end
   endtask

   initial begin
      logic [15:0] ew;
      logic [5:0]  el;
      logic [15:0] hw;
      logic [5:0]  hl;

      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 busy", busy, 0);
      check("R1 done", done, 0);
      check("R1 word", pll_word, 0);
      check("R1 lp", lp_code, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 word after release", pll_word, 0);

      for (int i = 0; i < NV; i++) begin
         kick(VEC[i][47:24], VEC[i][23:0]);
         // R8: busy one clock after start
         if (i == 0) begin
            check("R8 busy after start", busy, 1);
            check("R8 done low while busy", done, 0);
         end
         wait_done();
         model(longint'(VEC[i][47:24]), longint'(VEC[i][23:0]), ew, el);
         check("R8 busy low at done", busy, 0);
         check("R2 prediv", pll_word[12:8], ew[12:8]);
         check("R3 mult", pll_word[7:0], ew[7:0]);
         check("R4 band", pll_word[15:14], ew[15:14]);
         check("R5 bit13", pll_word[13], 0);
         check("R6 lp code", lp_code, el);
      end

      // R7: input changes and a second start during a run have no effect
      kick(24'd27000, 24'd500000);
      model(27000, 500000, ew, el);
      ref_khz = 24'd1000;
      lane_kbps = 24'd125000;
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done();
      check("R7 word unaffected", pll_word, ew);
      check("R7 lp unaffected", lp_code, el);
      repeat (3) @(negedge clk);
      check("R7 busy-time start dropped", busy, 0);

      // R7: outputs hold while idle with inputs moving
      hw = pll_word;
      hl = lp_code;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         ref_khz = 24'(k * 3001 + 7);
         lane_kbps = 24'(k * 77777);
      end
      check("R7 word held", pll_word, hw);
      check("R7 lp held", lp_code, hl);
      check("R8 done held", done, 1);

      // R8: done clears on accepted start
      kick(24'd1000, 24'd126000);
      check("R8 done cleared", done, 0);
      wait_done();
      model(1000, 126000, ew, el);
      check("R4 band after restart", pll_word[15:14], ew[15:14]);

      // R1: reset in the middle of a run
      kick(24'd24000, 24'd480000);
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 busy mid-run reset", busy, 0);
      check("R1 word mid-run reset", pll_word, 0);
      check("R1 lp mid-run reset", lp_code, 0);
      rst_n = 1'b1;

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 20);
      failures++;
      checks++;
      $display("FAIL R9 global watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule